// File: doc/BRIEF.md
# Double-Banked 8x8 Transpose Store

This block sits between the two passes of a separable 8x8 two-dimensional transform. The first pass delivers a block of 64 signed 16-bit values one per cycle, row by row. The second pass takes the same block back one value per cycle, column by column, so the block comes out transposed.

Two banks of storage let both passes run at once. While the producer fills one bank, the consumer drains the other. Ownership of a bank changes hands only at block boundaries. A bank goes to the consumer when its 64th value has been written. It goes back to the producer when its 64th value has been read.

Both sides use a valid/ready handshake: a transfer happens on a rising clock edge when valid and ready are both high. The read data is presented combinationally from the bank that the consumer currently owns.

Top module: `pp_transpose_buf`

## Requirements
- R1: After a synchronous active-low reset, both banks are empty and both bank selectors point at bank 0, so `in_ready` is 1 and `out_valid` is 0.
- R2: A value is stored only in a cycle where `in_valid` and `in_ready` are both high. It is returned bit-exact as a signed 16-bit value.
- R3: `out_valid` stays low until the 64th value of a block has been accepted. It goes high in the cycle that follows that acceptance.
- R4: Write position k (k = 0..63) holds row k/8, column k%8. The k-th read of a block returns the value written at position (k%8)*8 + k/8, which is column-major order.
- R5: When both banks hold complete blocks, `in_ready` is low. It returns high in the cycle after the 64th read of the older block.
- R6: When neither bank holds a complete block, `out_valid` is low. A bank is released to the producer only after all 64 of its values have been read.
- R7: The producer may fill one bank while the consumer drains the other. Blocks leave in the order they arrived.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R9: `in_valid` asserted while `in_ready` is low has no effect. The values offered in such cycles never appear at `out_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Producer offers a value |
| in_ready | output | 1 | A bank is free for writing |
| in_data | input | 16 | Signed value, row-major order |
| out_valid | output | 1 | A complete block is available |
| out_ready | input | 1 | Consumer takes the presented value |
| out_data | output | 16 | Signed value, column-major order |

## Verification
The hardest situation to reach from the ports is the same-edge case. In that cycle the producer finishes one bank while the consumer finishes the other, so both full flags and both selectors change on one edge. Reaching it needs both sides streaming at full rate with aligned phases.

The stimulus gets there in three steps. First it fills both banks with the consumer held off. It then releases both sides at a full duty cycle. A long run with random duty cycles follows, which drifts the producer and consumer phases through every relative offset. A behavioural queue model is compared against the outputs on every cycle.

// File: rtl/pptb_pkg.sv
// Package: shared geometry and helpers for the transpose store.
// Assumes the block side is at least 2 so index widths are non-zero.
package pptb_pkg;
    // Number of banks in the ping-pong pair.
    localparam int unsigned NUM_BANKS = 2;

    // Address inside a bank for a given row and column.
    function automatic int unsigned cell_addr(int unsigned row, int unsigned col, int unsigned dim);
        return row * dim + col;
    endfunction
endpackage

// File: rtl/pptb_bank.sv
// Module: one bank of block storage.
// One synchronous write port and one combinational read port.
// Assumes the controller never writes and reads the same bank in one cycle.
module pptb_bank #(
    parameter int unsigned DIM    = 8,
    parameter int unsigned DATA_W = 16,
    localparam int unsigned DEPTH = DIM * DIM,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic signed [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]            rd_addr,
    output logic signed [DATA_W-1:0] rd_data
);
    logic signed [DATA_W-1:0] mem_q [DEPTH];

    // Store one element when the bank is the write target.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Present the addressed element without a register stage.
    always_comb begin
        rd_data = mem_q[rd_addr];
    end
endmodule

// File: rtl/pptb_seq.sv
// Module: address sequencer for one side of the store.
// It walks an inner and an outer index across the block.
// COL_MAJOR=0: the outer index is the row, so the walk is row-major (write side).
// COL_MAJOR=1: the outer index is the column, so the walk is column-major (read side).
// Assumes step is only asserted on an accepted transfer.
module pptb_seq #(
    parameter int unsigned DIM       = 8,
    parameter bit          COL_MAJOR = 1'b0,
    localparam int unsigned DEPTH    = DIM * DIM,
    localparam int unsigned AW       = $clog2(DEPTH),
    localparam int unsigned IW       = $clog2(DIM)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          last
);
    logic [IW-1:0] inner_q;
    logic [IW-1:0] outer_q;
    logic          inner_end;

    assign inner_end = (inner_q == IW'(DIM - 1));
    assign last      = inner_end && (outer_q == IW'(DIM - 1));

    // Advance the inner index and carry into the outer index at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inner_q <= '0;
            outer_q <= '0;
        end else if (step) begin
            if (inner_end) begin
                inner_q <= '0;
                outer_q <= last ? '0 : outer_q + 1'b1;
            end else begin
                inner_q <= inner_q + 1'b1;
            end
        end
    end

    // Map the index pair onto a bank address according to the walk order.
    generate
        if (COL_MAJOR) begin : g_col
            always_comb begin
                addr = AW'(pptb_pkg::cell_addr(int'(inner_q), int'(outer_q), DIM));
            end
        end else begin : g_row
            always_comb begin
                addr = AW'(pptb_pkg::cell_addr(int'(outer_q), int'(inner_q), DIM));
            end
        end
    endgenerate
endmodule

// File: rtl/pptb_ctrl.sv
// Module: bank ownership control.
// Holds a full flag per bank and a one-bit selector for each side.
// A bank is marked full on its last write and marked empty on its last read.
// Assumes the write selector always names an empty bank when it writes and
// the read selector always names a full one when it reads, so the two
// updates never touch the same flag on one edge.
module pptb_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    input  logic wr_last,
    input  logic rd_last,
    output logic in_ready,
    output logic out_valid,
    output logic wr_fire,
    output logic rd_fire,
    output logic wr_sel,
    output logic rd_sel
);
    logic [pptb_pkg::NUM_BANKS-1:0] full_q;
    logic                           wr_sel_q;
    logic                           rd_sel_q;

    assign in_ready  = !full_q[wr_sel_q];
    assign out_valid = full_q[rd_sel_q];
    assign wr_fire   = in_valid && in_ready;
    assign rd_fire   = out_valid && out_ready;
    assign wr_sel    = wr_sel_q;
    assign rd_sel    = rd_sel_q;

    // Hand a bank over at each block boundary, in either direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q   <= '0;
            wr_sel_q <= 1'b0;
            rd_sel_q <= 1'b0;
        end else begin
            if (wr_fire && wr_last) begin
                full_q[wr_sel_q] <= 1'b1;
                wr_sel_q         <= ~wr_sel_q;
            end
            if (rd_fire && rd_last) begin
                full_q[rd_sel_q] <= 1'b0;
                rd_sel_q         <= ~rd_sel_q;
            end
        end
    end
endmodule

// File: rtl/pp_transpose_buf.sv
// Module: double-banked transpose store.
// It takes an 8x8 block written by rows and returns it read by columns.
// Two banks let the writer fill one block while the reader drains the
// previous one. Assumes one transfer per cycle at most on each side.
module pp_transpose_buf #(
    parameter int unsigned DIM    = 8,
    parameter int unsigned DATA_W = 16,
    localparam int unsigned DEPTH = DIM * DIM,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic signed [DATA_W-1:0] out_data
);
    logic          wr_fire;
    logic          rd_fire;
    logic          wr_sel;
    logic          rd_sel;
    logic          wr_last;
    logic          rd_last;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;
    logic signed [DATA_W-1:0] bank_rd [pptb_pkg::NUM_BANKS];

    pptb_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .wr_last   (wr_last),
        .rd_last   (rd_last),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .wr_fire   (wr_fire),
        .rd_fire   (rd_fire),
        .wr_sel    (wr_sel),
        .rd_sel    (rd_sel)
    );

    pptb_seq #(.DIM(DIM), .COL_MAJOR(1'b0)) u_wr_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (wr_fire),
        .addr  (wr_addr),
        .last  (wr_last)
    );

    pptb_seq #(.DIM(DIM), .COL_MAJOR(1'b1)) u_rd_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (rd_fire),
        .addr  (rd_addr),
        .last  (rd_last)
    );

    generate
        for (genvar b = 0; b < int'(pptb_pkg::NUM_BANKS); b++) begin : g_bank
            logic bank_we;
            // Enable the write only on the bank the producer currently owns.
            always_comb begin
                bank_we = wr_fire && (wr_sel == 1'(b));
            end
            pptb_bank #(.DIM(DIM), .DATA_W(DATA_W)) u_bank (
                .clk     (clk),
                .wr_en   (bank_we),
                .wr_addr (wr_addr),
                .wr_data (in_data),
                .rd_addr (rd_addr),
                .rd_data (bank_rd[b])
            );
        end
    endgenerate

    // Route the consumer-owned bank to the output.
    always_comb begin
        out_data = bank_rd[rd_sel];
    end
endmodule

// File: rtl/pptb_checker.sv
// Module: protocol checker for the transpose store, attached by bind.
// It counts completed blocks on each side from the port handshakes alone.
module pptb_checker #(
    parameter int unsigned DIM    = 8,
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data
);
    localparam int unsigned DEPTH = DIM * DIM;

    int unsigned wr_elems, rd_elems, blk_in, blk_out;
    logic        after_rst;

    // Track element and block counts seen at the two handshakes.
    always_ff @(posedge clk) begin
        after_rst <= !rst_n;
        if (!rst_n) begin
            wr_elems <= 0; rd_elems <= 0; blk_in <= 0; blk_out <= 0;
        end else begin
            if (in_valid && in_ready) begin
                if (wr_elems == DEPTH - 1) begin
                    wr_elems <= 0;
                    blk_in   <= blk_in + 1;
                end else begin
                    wr_elems <= wr_elems + 1;
                end
            end
            if (out_valid && out_ready) begin
                if (rd_elems == DEPTH - 1) begin
                    rd_elems <= 0;
                    blk_out  <= blk_out + 1;
                end else begin
                    rd_elems <= rd_elems + 1;
                end
            end
        end
    end

    // R1: the cycle after reset shows an idle, writable store.
    p_reset_state_r1: assert property (@(posedge clk)
        (after_rst === 1'b1) && rst_n |-> in_ready && !out_valid);

    // R3 / R6: data is offered exactly when a complete block is pending.
    p_valid_needs_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (blk_in > blk_out));
    p_empty_no_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_in == blk_out) |-> !out_valid);

    // R5: never more than two blocks are held.
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_in - blk_out) <= 2);
    p_full_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_in - blk_out == 2) |-> !in_ready);

    // R5: a stalled writer is freed only by a read.
    p_ready_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready && !(out_valid && out_ready) |=> !in_ready);

    // R8: presented data holds while the consumer stalls.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

bind pp_transpose_buf pptb_checker #(.DIM(DIM), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/pp_transpose_buf_tb.sv
`timescale 1ns/1ps
// Bench: behavioural queue model compared against the outputs on every cycle.
module pp_transpose_buf_tb_top;
    typedef logic signed [15:0] blk_t [64];

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic out_ready = 1'b0;
    logic signed [15:0] in_data = '0;
    logic in_ready, out_valid;
    logic signed [15:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    blk_t done_q[$];
    blk_t cur_w;
    int   wpos = 0;
    int   rpos = 0;

    always #5 clk = ~clk;

    pp_transpose_buf dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        done_q.delete();
        wpos = 0;
        rpos = 0;
    endtask

    // Compare the outputs with the model at the falling edge.
    task automatic compare(string tag);
        logic exp_rdy, exp_vld;
        exp_rdy = (done_q.size() < 2);
        exp_vld = (done_q.size() > 0);
        check({"R5 in_ready ", tag}, 16'(in_ready), 16'(exp_rdy));
        check({"R3/R6 out_valid ", tag}, 16'(out_valid), 16'(exp_vld));
        if (exp_vld)
            check({"R2/R4 out_data ", tag}, out_data,
                  done_q[0][(rpos % 8) * 8 + rpos / 8]);
    endtask

    // Run cycles with given duty cycles; the model advances on each predicted transfer.
    task automatic run(int cycles, int pv, int pr, string tag);
        for (int c = 0; c < cycles; c++) begin
            bit wf, rf;
            @(negedge clk);
            compare(tag);
            in_valid  = ($urandom_range(99) < pv);
            out_ready = ($urandom_range(99) < pr);
            in_data   = 16'($urandom);
            wf = in_valid && (done_q.size() < 2);
            rf = out_ready && (done_q.size() > 0);
            if (rf) begin
                rpos++;
                if (rpos == 64) begin
                    void'(done_q.pop_front());
                    rpos = 0;
                end
            end
            if (wf) begin
                cur_w[wpos] = in_data;
                wpos++;
                if (wpos == 64) begin
                    done_q.push_back(cur_w);
                    wpos = 0;
                end
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: idle outputs during reset.
        check("R1 in_ready at reset", 16'(in_ready), 16'd1);
        check("R1 out_valid at reset", 16'(out_valid), 16'd0);
        rst_n = 1'b1;
        model_reset();
        run(140, 100, 0, "R3 fill both banks");
        run(40, 100, 0, "R9 writes offered while full");
        run(140, 0, 100, "R6 drain");
        run(400, 100, 0, "R3 refill");
        run(600, 100, 100, "R7 full-rate overlap");
        run(3000, 60, 50, "R8 random stalls");
        run(300, 100, 20, "R9 slow consumer");
        // R1: reset in the middle of a block empties the store.
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        out_ready = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        check("R1 in_ready after mid-run reset", 16'(in_ready), 16'd1);
        check("R1 out_valid after mid-run reset", 16'(out_valid), 16'd0);
        run(500, 80, 80, "R7 after reset");
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule